// File: doc/BRIEF.md
# Oversampling Serial Receiver with Majority Voting

This block turns an asynchronous serial line into 8-bit characters. It counts a shared tick that runs at 16 times the baud rate, so one bit period lasts 16 ticks. The raw line first passes through a two-flop synchronizer. A falling edge while idle arms the receiver. The start bit is then confirmed at its centre before any data is taken, so a short low glitch returns the receiver to idle without a frame.

Every bit, start and stop included, is decided by a 2-of-3 majority of samples taken at ticks 7, 8 and 9 of its period, counting from 0. Data arrives least significant bit first. The decision for each bit falls at tick 9. A high stop bit delivers the byte as a one-cycle valid pulse with the data beside it, and the receiver re-arms at once, so a following start edge is never missed. A low stop bit drops the byte and raises a one-cycle framing-error pulse instead. Only the first stop bit is checked. Extra stop bits are just idle line. A low receive enable holds the receiver idle and silences both outputs.

Top module: `uart_osr_rx`

## Requirements
- R1: After reset, `rx_valid_o` and `frame_err_o` are 0 and `rx_data_o` is 0.
- R2: A frame is a low start bit, 8 data bits with bit 0 first, then a high stop bit, each 16 ticks long. It produces exactly one `rx_valid_o` pulse one clock wide, and `rx_data_o` carries the byte. `rx_data_o` changes only in a cycle where `rx_valid_o` is 1.
- R3: A single wrong sample among ticks 7, 8 and 9 of a bit, in the start bit or a data bit, does not change the received byte.
- R4: Bit values come from ticks 7, 8 and 9 only. If ticks 8 and 9 of a data bit are both inverted, that bit is received inverted.
- R5: A low pulse that has ended before tick 7 of the would-be start bit produces no valid and no framing error. The next real frame is then received correctly.
- R6: A low stop bit produces no valid pulse and one `frame_err_o` pulse one clock wide. The two outputs are never high in the same cycle, and the next frame is received normally.
- R7: While `rx_en_i` is 0, the line is ignored and neither output pulses. Dropping `rx_en_i` in the middle of a frame abandons that frame. Frames after re-enabling are received normally.
- R8: Two frames sent back to back, with a single stop bit between them, are both received in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_serial_i | input | 1 | Raw asynchronous serial line, idle high |
| os_tick_i | input | 1 | One-clock pulse at 16 times the baud rate |
| rx_en_i | input | 1 | Receive enable, 1 = receive |
| rx_valid_o | output | 1 | One-cycle pulse: a good byte is on `rx_data_o` |
| rx_data_o | output | 8 | Last byte received, held between pulses |
| frame_err_o | output | 1 | One-cycle pulse: the stop bit was voted low |

## Verification
A tick counter that is off by even one position moves the vote window. The bench's two-sample corruption at ticks 8 and 9 then stops flipping the bit, or a one-sample corruption starts flipping it. That shows up in `rx_data_o` at the stop-bit centre of the same frame, about 150 ticks after the start edge. A phase register that is stuck, or that fails to return to idle, shows up as a missing or extra valid or framing-error pulse within one frame time. Late re-arming after the stop bit shows up only as a lost second byte in the back-to-back case.

// File: rtl/uart_osr_pkg.sv
package uart_osr_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_phase_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/uart_osr_sync.sv
module uart_osr_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("uart_osr_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RESET_VAL}};
      end else begin
         chain_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) begin
            chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_osr_tickcnt.sv
module uart_osr_tickcnt #(
   parameter int OSR   = 16,
   parameter int CNT_W = $clog2(OSR)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             tick_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

   generate
      if (OSR < 4) begin : g_bad_osr
         $error("uart_osr_tickcnt: OSR must be at least 4");
      end
      if (CNT_W != $clog2(OSR)) begin : g_bad_w
         $error("uart_osr_tickcnt: CNT_W does not match OSR");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
      end else if (clear_i) begin
         cnt_o <= '0;
      end else if (tick_i) begin
         cnt_o <= (cnt_o == LAST) ? '0 : cnt_o + 1'b1;
      end
   end
endmodule

// File: rtl/uart_osr_vote.sv
module uart_osr_vote #(
   parameter int OSR   = 16,
   parameter int CNT_W = $clog2(OSR)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             line_i,
   output logic             decide_o,
   output logic             bit_o
);
   import uart_osr_pkg::*;

   localparam logic [CNT_W-1:0] POS_A = CNT_W'(OSR / 2 - 1);
   localparam logic [CNT_W-1:0] POS_B = CNT_W'(OSR / 2);
   localparam logic [CNT_W-1:0] POS_C = CNT_W'(OSR / 2 + 1);

   generate
      if (OSR / 2 + 1 >= OSR) begin : g_bad_window
         $error("uart_osr_vote: vote window does not fit in a bit period");
      end
   endgenerate

   logic samp_a_q, samp_b_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp_a_q <= 1'b1;
         samp_b_q <= 1'b1;
      end else if (tick_i) begin
         if (cnt_i == POS_A) samp_a_q <= line_i;
         if (cnt_i == POS_B) samp_b_q <= line_i;
      end
   end

   assign decide_o = tick_i && (cnt_i == POS_C);
   assign bit_o    = maj3(samp_a_q, samp_b_q, line_i);
endmodule

// File: rtl/uart_osr_rx.sv
module uart_osr_rx #(
   parameter int DATA_BITS   = 8,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_serial_i,
   input  logic                 os_tick_i,
   input  logic                 rx_en_i,
   output logic                 rx_valid_o,
   output logic [DATA_BITS-1:0] rx_data_o,
   output logic                 frame_err_o
);
   import uart_osr_pkg::*;

   localparam int CNT_W = $clog2(OSR);
   localparam int IDX_W = $clog2(DATA_BITS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

   generate
      if (DATA_BITS < 2) begin : g_bad_bits
         $error("uart_osr_rx: DATA_BITS must be at least 2");
      end
   endgenerate

   logic             line_s, line_prev_q, fall;
   logic [CNT_W-1:0] tick_cnt;
   logic             cnt_clear, decide, vbit;
   rx_phase_e        phase_q;
   logic [IDX_W-1:0] idx_q;
   logic [DATA_BITS-1:0] shift_q;

   uart_osr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rx_serial_i),
      .q_o   (line_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_prev_q <= 1'b1;
      else        line_prev_q <= line_s;
   end

   assign fall      = line_prev_q & ~line_s;
   assign cnt_clear = (phase_q == RX_IDLE) || !rx_en_i;

   uart_osr_tickcnt #(.OSR(OSR), .CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (cnt_clear),
      .tick_i  (os_tick_i),
      .cnt_o   (tick_cnt)
   );

   uart_osr_vote #(.OSR(OSR), .CNT_W(CNT_W)) u_vote (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (os_tick_i),
      .cnt_i    (tick_cnt),
      .line_i   (line_s),
      .decide_o (decide),
      .bit_o    (vbit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= RX_IDLE;
         idx_q       <= '0;
         shift_q     <= '0;
         rx_data_o   <= '0;
         rx_valid_o  <= 1'b0;
         frame_err_o <= 1'b0;
      end else begin
         rx_valid_o  <= 1'b0;
         frame_err_o <= 1'b0;
         if (!rx_en_i) begin
            phase_q <= RX_IDLE;
         end else begin
            unique case (phase_q)
               RX_IDLE: begin
                  if (fall) phase_q <= RX_START;
               end
               RX_START: begin
                  if (decide) begin
                     idx_q   <= '0;
                     phase_q <= vbit ? RX_IDLE : RX_DATA;
                  end
               end
               RX_DATA: begin
                  if (decide) begin
                     shift_q <= {vbit, shift_q[DATA_BITS-1:1]};
                     if (idx_q == LAST_IDX) phase_q <= RX_STOP;
                     else                   idx_q   <= idx_q + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (decide) begin
                     if (vbit) begin
                        rx_valid_o <= 1'b1;
                        rx_data_o  <= shift_q;
                     end else begin
                        frame_err_o <= 1'b1;
                     end
                     phase_q <= RX_IDLE;
                  end
               end
               default: phase_q <= RX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_osr_rx_chk.sv
module uart_osr_rx_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_en_i,
   input logic          rx_valid_o,
   input logic          frame_err_o,
   input logic [DW-1:0] rx_data_o
);
   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o); // R2
   AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid_o |-> $stable(rx_data_o)); // R2
   AST_FERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o |=> !frame_err_o); // R6
   AST_NO_VALID_WITH_FERR: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_valid_o && frame_err_o)); // R6
   AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en_i |=> (!rx_valid_o && !frame_err_o)); // R7
endmodule

bind uart_osr_rx uart_osr_rx_chk #(.DW(DATA_BITS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_en_i     (rx_en_i),
   .rx_valid_o  (rx_valid_o),
   .frame_err_o (frame_err_o),
   .rx_data_o   (rx_data_o)
);

// File: tb/test_uart_osr_rx.sv
`timescale 1ns/1ps
module test_uart_osr_rx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line = 1'b1;
   logic       rx_en = 1'b0;
   logic       rx_valid, frame_err;
   logic [7:0] rx_data;
   logic [1:0] div = 2'd0;
   logic       tick16;

   int checks = 0;
   int errors = 0;
   int nvalid = 0;
   int nferr  = 0;
   logic [7:0] log_q [0:7];

   always #4 clk = ~clk;

   always @(negedge clk) begin
      if (!rst_n) div <= 2'd0;
      else        div <= div + 2'd1;
   end
   assign tick16 = (div == 2'd3);

   uart_osr_rx i_uart_osr_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_serial_i (line),
      .os_tick_i   (tick16),
      .rx_en_i     (rx_en),
      .rx_valid_o  (rx_valid),
      .rx_data_o   (rx_data),
      .frame_err_o (frame_err)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_valid) begin
            if (nvalid < 8) log_q[nvalid] = rx_data;
            nvalid = nvalid + 1;
         end
         if (frame_err) nferr = nferr + 1;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_tick();
      do @(posedge clk); while (tick16 !== 1'b1);
      @(negedge clk);
   endtask

   task automatic idle_ticks(input int n);
      line = 1'b1;
      for (int i = 0; i < n; i++) wait_tick();
   endtask

   task automatic clear_mon();
      nvalid = 0;
      nferr  = 0;
   endtask

   // frame slots: 0 start, 1..8 data bit 0..7, 9 stop
   task automatic drive_frame(input logic [7:0] b, input logic stop_v,
                              input int noise_slot, input int noise_len, input int dis_slot);
      for (int j = 0; j < 10; j++) begin
         logic v;
         v = (j == 0) ? 1'b0 : (j == 9) ? stop_v : b[j-1];
         if (j == dis_slot) rx_en = 1'b0;
         for (int t = 0; t < 16; t++) begin
            line = (j == noise_slot && t >= 8 && t < 8 + noise_len) ? ~v : v;
            wait_tick();
         end
      end
      line = 1'b1;
   endtask

   task automatic expect_one(input string req, input logic [7:0] b, input logic [7:0] exp);
      clear_mon();
      drive_frame(b, 1'b1, -1, 0, -1);
      idle_ticks(4);
      chk(req, "valid count", nvalid, 1);
      chk(req, "data", int'(log_q[0]), int'(exp));
   endtask

   task automatic t_reset();
      chk("R1", "valid after reset", int'(rx_valid), 0);
      chk("R1", "ferr after reset", int'(frame_err), 0);
      chk("R1", "data after reset", int'(rx_data), 0);
   endtask

   task automatic t_basic();
      expect_one("R2", 8'h01, 8'h01);
      expect_one("R2", 8'hC3, 8'hC3);
      expect_one("R2", 8'hA5, 8'hA5);
      chk("R2", "data held after pulse", int'(rx_data), 8'hA5);
      chk("R2", "no ferr", nferr, 0);
   endtask

   task automatic t_noise_one();
      clear_mon();
      drive_frame(8'h5A, 1'b1, 2, 1, -1);
      idle_ticks(4);
      chk("R3", "data bit noise count", nvalid, 1);
      chk("R3", "data bit noise value", int'(log_q[0]), 8'h5A);
      clear_mon();
      drive_frame(8'h96, 1'b1, 0, 1, -1);
      idle_ticks(4);
      chk("R3", "start noise count", nvalid, 1);
      chk("R3", "start noise value", int'(log_q[0]), 8'h96);
   endtask

   task automatic t_noise_two();
      clear_mon();
      drive_frame(8'h00, 1'b1, 4, 2, -1);
      idle_ticks(4);
      chk("R4", "two-vote count", nvalid, 1);
      chk("R4", "two-vote value", int'(log_q[0]), 8'h08);
   endtask

   task automatic t_glitch();
      clear_mon();
      line = 1'b0;
      for (int i = 0; i < 4; i++) wait_tick();
      idle_ticks(24);
      chk("R5", "glitch valid", nvalid, 0);
      chk("R5", "glitch ferr", nferr, 0);
      expect_one("R5", 8'h3C, 8'h3C);
   endtask

   task automatic t_frame_err();
      clear_mon();
      drive_frame(8'hA5, 1'b0, -1, 0, -1);
      idle_ticks(4);
      chk("R6", "bad stop valid", nvalid, 0);
      chk("R6", "bad stop ferr", nferr, 1);
      expect_one("R6", 8'h7E, 8'h7E);
      chk("R6", "no ferr on good frame", nferr, 0);
   endtask

   task automatic t_disable();
      rx_en = 1'b0;
      clear_mon();
      drive_frame(8'h55, 1'b1, -1, 0, -1);
      idle_ticks(4);
      chk("R7", "disabled valid", nvalid, 0);
      chk("R7", "disabled ferr", nferr, 0);
      rx_en = 1'b1;
      idle_ticks(4);
      clear_mon();
      drive_frame(8'h55, 1'b1, -1, 0, 4);
      idle_ticks(4);
      chk("R7", "mid-frame drop valid", nvalid, 0);
      chk("R7", "mid-frame drop ferr", nferr, 0);
      rx_en = 1'b1;
      idle_ticks(4);
      expect_one("R7", 8'h69, 8'h69);
   endtask

   task automatic t_back_to_back();
      clear_mon();
      drive_frame(8'h33, 1'b1, -1, 0, -1);
      drive_frame(8'hCC, 1'b1, -1, 0, -1);
      idle_ticks(4);
      chk("R8", "pair count", nvalid, 2);
      chk("R8", "first byte", int'(log_q[0]), 8'h33);
      chk("R8", "second byte", int'(log_q[1]), 8'hCC);
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      rx_en = 1'b1;
      idle_ticks(8);
      t_basic();
      t_noise_one();
      t_noise_two();
      t_glitch();
      t_frame_err();
      t_disable();
      t_back_to_back();
      summary();
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog all-requirements actual=timeout expected=done");
      summary();
   end
endmodule